// File: doc/BRIEF.md
# Two-Converter Interleaved Sample Merger

This block joins the outputs of two 12-bit converters into one ordered sample stream at twice the rate of either. The two converters sample the same input on clocks half a period apart. The *lead* converter samples on the rising phase and the *lag* converter samples half a sample period later. Each converter delivers one parallel word per fabric clock. A word holds `LANES` samples, with the earliest sample in the least significant lane. The merger scales each converter's samples by its own gain coefficient, so that the two converters match in amplitude. It then rounds and clamps each result and writes out one word of `2*LANES` samples in true time order.

Both input channels share a single valid/ready handshake. A word is taken only in a cycle where both channel valids are high and `in_ready` is high. The output is a valid/ready stream. While `out_valid` is high and `out_ready` is low, the word on `out_data` is held unchanged. The internal two-stage pipeline then fills, and after that `in_ready` drops. The gain coefficients are loaded through a plain write strobe. There is no offset term, because offset is trimmed in the analog domain ahead of the converters.

Top module: `tiadc_merge`

## Requirements
- R1: After reset, `out_valid` is 0 and `align_err` is 0. Both gain coefficients are 0x8000, which is exactly 1.0, so a word sent without any gain write passes through unchanged.
- R2: A word is accepted only on a rising clock edge where `lead_valid`, `lag_valid` and `in_ready` are all 1. Every accepted word produces exactly one output word, in acceptance order. While `out_valid` is 0, `in_ready` is 1.
- R3: Output lane 2k (bits [24k+11:24k]) holds lead lane k, and output lane 2k+1 holds lag lane k. Input lane k occupies bits [12k+11:12k]. Lane 0 is the earliest sample in time.
- R4: Samples are two's complement. Each gain is unsigned with 1 integer bit and 15 fraction bits. An output sample is floor((sample*gain + 16384) / 32768), so halves round toward plus infinity. For example, 3 at gain 0.5 gives 2, and -3 at gain 0.5 gives -1.
- R5: A scaled result above 2047 is output as 2047. A scaled result below -2048 is output as -2048. Results never wrap.
- R6: No offset is added. A zero sample gives zero under any gain.
- R7: A gain write applies to the words accepted in later cycles. A word accepted in the same cycle as the write still uses the previous gain, and every lane of that word uses one gain.
- R8: In any cycle where `lead_valid` differs from `lag_valid`, `align_err` becomes 1 from the next cycle on. It stays 1 until reset. The unmatched beat produces no output word.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold their values. With the output stalled, at most two words are buffered before `in_ready` drops.
- R10: A write with `cfg_sel` = 0 loads the lead gain, and a write with `cfg_sel` = 1 loads the lag gain. The other gain is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lead_valid | input | 1 | Lead converter word valid |
| lead_data | input | LANES*12 | Lead converter samples, lane 0 earliest |
| lag_valid | input | 1 | Lag converter word valid |
| lag_data | input | LANES*12 | Lag converter samples, lane 0 earliest |
| in_ready | output | 1 | Merger can accept a word pair |
| cfg_wr | input | 1 | Gain write strobe |
| cfg_sel | input | 1 | Gain select: 0 lead, 1 lag |
| cfg_wdata | input | 16 | Gain value, 1.15 unsigned |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | LANES*24 | Merged corrected samples in time order |
| align_err | output | 1 | Sticky channel valid mismatch flag |

## Verification
The bench uses odd samples at gain 0.5 to reach the exact-half rounding case in both signs. A truncating or round-half-away design would give 1 or -2 in those places. Gains near 2.0 on full-scale samples of both signs test the clamp, which a wrapping design would fail by flipping the sign. A gain write is issued in the very cycle a word is accepted, so a design that applies the new gain early, or to only part of a word, gives a mismatched word. Output stalls and a skewed-valid beat test word retention, the sticky flag, and whether a lone beat leaks into the stream as a spurious word.

// File: rtl/tiadc_pkg.sv
package tiadc_pkg;
  typedef enum logic {
    CH_LEAD = 1'b0,
    CH_LAG  = 1'b1
  } tiadc_ch_e;

  localparam int TIADC_NUM_CH = 2;
endpackage

// File: rtl/tiadc_gain_regs.sv
module tiadc_gain_regs
  import tiadc_pkg::*;
#(
  parameter int GAIN_W = 16,
  parameter int GAIN_FRAC = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [GAIN_W-1:0] cfg_wdata,
  output logic [GAIN_W-1:0] gain_lead,
  output logic [GAIN_W-1:0] gain_lag
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << GAIN_FRAC;

  logic [GAIN_W-1:0] gain_q [TIADC_NUM_CH];

  for (genvar c = 0; c < TIADC_NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gain_q[c] <= UNITY;
      end else if (cfg_wr && (cfg_sel == c[0])) begin
        gain_q[c] <= cfg_wdata;
      end
    end
  end

  assign gain_lead = gain_q[CH_LEAD];
  assign gain_lag  = gain_q[CH_LAG];
endmodule

// File: rtl/tiadc_lane_mul.sv
module tiadc_lane_mul #(
  parameter int SAMPLE_W = 12,
  parameter int GAIN_W = 16,
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [GAIN_W-1:0]   gain,
  output logic signed [PROD_W-1:0]   prod
);
  logic signed [GAIN_W:0]   gain_s;
  logic signed [PROD_W-1:0] samp_x;
  logic signed [PROD_W-1:0] gain_x;

  always_comb begin
    gain_s = $signed({1'b0, gain});
    samp_x = PROD_W'(sample);
    gain_x = PROD_W'(gain_s);
    prod   = samp_x * gain_x;
  end
endmodule

// File: rtl/tiadc_round_sat.sv
module tiadc_round_sat #(
  parameter int SAMPLE_W = 12,
  parameter int PROD_W = 29,
  parameter int FRAC = 15
) (
  input  logic signed [PROD_W-1:0]   prod,
  output logic        [SAMPLE_W-1:0] sample
);
  localparam int SUM_W = PROD_W + 1;
  localparam int HALF = 1 << (FRAC - 1);
  localparam int MAXI = (1 << (SAMPLE_W - 1)) - 1;
  localparam int MINI = -(1 << (SAMPLE_W - 1));
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'(MAXI);
  localparam logic signed [SUM_W-1:0] MINV = SUM_W'(MINI);

  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] shifted;

  always_comb begin
    sum     = SUM_W'(prod) + $signed(SUM_W'(HALF));
    shifted = sum >>> FRAC;
    if (shifted > MAXV) begin
      sample = MAXV[SAMPLE_W-1:0];
    end else if (shifted < MINV) begin
      sample = MINV[SAMPLE_W-1:0];
    end else begin
      sample = shifted[SAMPLE_W-1:0];
    end
  end
endmodule

// File: rtl/tiadc_channel.sv
module tiadc_channel #(
  parameter int LANES = 4,
  parameter int SAMPLE_W = 12,
  parameter int GAIN_W = 16,
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [LANES*SAMPLE_W-1:0] samples,
  input  logic [GAIN_W-1:0]         gain,
  output logic [LANES*PROD_W-1:0]   prod_q
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [PROD_W-1:0] prod_c;

    tiadc_lane_mul #(
      .SAMPLE_W(SAMPLE_W),
      .GAIN_W  (GAIN_W)
    ) u_mul (
      .sample(samples[k*SAMPLE_W +: SAMPLE_W]),
      .gain  (gain),
      .prod  (prod_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prod_q[k*PROD_W +: PROD_W] <= '0;
      end else if (load) begin
        prod_q[k*PROD_W +: PROD_W] <= prod_c;
      end
    end
  end
endmodule

// File: rtl/tiadc_merge.sv
module tiadc_merge #(
  parameter int LANES = 4,
  parameter int SAMPLE_W = 12,
  parameter int GAIN_W = 16,
  parameter int GAIN_FRAC = 15,
  localparam int IN_W = LANES * SAMPLE_W,
  localparam int OUT_W = 2 * IN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lead_valid,
  input  logic [IN_W-1:0]   lead_data,
  input  logic              lag_valid,
  input  logic [IN_W-1:0]   lag_data,
  output logic              in_ready,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [GAIN_W-1:0] cfg_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_data,
  output logic              align_err
);
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

  logic [GAIN_W-1:0]       gain_lead;
  logic [GAIN_W-1:0]       gain_lag;
  logic [LANES*PROD_W-1:0] lead_prod;
  logic [LANES*PROD_W-1:0] lag_prod;
  logic [OUT_W-1:0]        out_next;
  logic                    mid_valid;
  logic                    out_open;
  logic                    take;
  logic                    advance;

  assign out_open = !out_valid || out_ready;
  assign in_ready = !mid_valid || out_open;
  assign take     = lead_valid && lag_valid && in_ready;
  assign advance  = mid_valid && out_open;

  tiadc_gain_regs #(
    .GAIN_W   (GAIN_W),
    .GAIN_FRAC(GAIN_FRAC)
  ) u_gains (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .gain_lead(gain_lead),
    .gain_lag (gain_lag)
  );

  tiadc_channel #(
    .LANES(LANES), .SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)
  ) u_lead (
    .clk(clk), .rst_n(rst_n), .load(take),
    .samples(lead_data), .gain(gain_lead), .prod_q(lead_prod)
  );

  tiadc_channel #(
    .LANES(LANES), .SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)
  ) u_lag (
    .clk(clk), .rst_n(rst_n), .load(take),
    .samples(lag_data), .gain(gain_lag), .prod_q(lag_prod)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_ilv
    tiadc_round_sat #(
      .SAMPLE_W(SAMPLE_W), .PROD_W(PROD_W), .FRAC(GAIN_FRAC)
    ) u_rs_lead (
      .prod  (lead_prod[k*PROD_W +: PROD_W]),
      .sample(out_next[(2*k)*SAMPLE_W +: SAMPLE_W])
    );
    tiadc_round_sat #(
      .SAMPLE_W(SAMPLE_W), .PROD_W(PROD_W), .FRAC(GAIN_FRAC)
    ) u_rs_lag (
      .prod  (lag_prod[k*PROD_W +: PROD_W]),
      .sample(out_next[(2*k+1)*SAMPLE_W +: SAMPLE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_valid <= 1'b0;
    end else if (take) begin
      mid_valid <= 1'b1;
    end else if (advance) begin
      mid_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (advance) begin
      out_valid <= 1'b1;
      out_data  <= out_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      align_err <= 1'b0;
    end else if (lead_valid != lag_valid) begin
      align_err <= 1'b1;
    end
  end
endmodule

// File: rtl/tiadc_merge_checker.sv
module tiadc_merge_checker #(
  parameter int OUT_W = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lead_valid,
  input logic             lag_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             align_err
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !align_err));

  a_r2_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r8_flag_on_skew: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_valid != lag_valid) |=> align_err);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> align_err);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind tiadc_merge tiadc_merge_checker #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lead_valid(lead_valid),
  .lag_valid (lag_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .align_err (align_err)
);

// File: tb/tiadc_merge_bench.sv
module tiadc_merge_bench;
  localparam int LANES = 4;
  localparam int SW = 12;
  localparam int IN_W = LANES * SW;
  localparam int OUT_W = 2 * IN_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lead_valid = 1'b0, lag_valid = 1'b0;
  logic [IN_W-1:0] lead_data = '0, lag_data = '0;
  logic in_ready;
  logic cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic out_valid;
  logic out_ready;
  logic [OUT_W-1:0] out_data;
  logic align_err;

  int checks = 0;
  int failures = 0;
  int bp_mode = 0;
  int gm_lead = 32768;
  int gm_lag = 32768;
  logic [OUT_W-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  tiadc_merge u_tiadc_merge (
    .clk(clk), .rst_n(rst_n),
    .lead_valid(lead_valid), .lead_data(lead_data),
    .lag_valid(lag_valid), .lag_data(lag_data),
    .in_ready(in_ready),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .align_err(align_err)
  );

  always @(negedge clk) begin
    case (bp_mode)
      1:       out_ready <= 1'b0;
      2:       out_ready <= (($urandom % 4) != 0);
      default: out_ready <= 1'b1;
    endcase
  end

  task automatic check(input bit ok, input string req,
                       input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int scale(input logic [SW-1:0] s, input int g);
    longint p;
    p = longint'($signed(s)) * longint'(g);
    p = (p + 16384) >>> 15;
    if (p > 2047) p = 2047;
    if (p < -2048) p = -2048;
    return int'(p);
  endfunction

  function automatic logic [IN_W-1:0] pk(input int v0, input int v1, input int v2, input int v3);
    return {v3[SW-1:0], v2[SW-1:0], v1[SW-1:0], v0[SW-1:0]};
  endfunction

  function automatic logic [OUT_W-1:0] expect_word(input logic [IN_W-1:0] a,
                                                   input logic [IN_W-1:0] b);
    logic [OUT_W-1:0] w;
    int r;
    for (int k = 0; k < LANES; k++) begin
      r = scale(a[k*SW +: SW], gm_lead);
      w[(2*k)*SW +: SW] = r[SW-1:0];
      r = scale(b[k*SW +: SW], gm_lag);
      w[(2*k+1)*SW +: SW] = r[SW-1:0];
    end
    return w;
  endfunction

  // Monitor: the transfer happens at the following rising edge.
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R8 unexpected word", out_data, '0);
      end else begin
        logic [OUT_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_data === e, t, out_data, e);
      end
    end
  end

  task automatic send(input logic [IN_W-1:0] a, input logic [IN_W-1:0] b,
                      input string tag, input bit wr, input bit sel, input int wval);
    @(negedge clk);
    lead_valid = 1'b1; lag_valid = 1'b1;
    lead_data = a; lag_data = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    if (wr) begin
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = wval[15:0];
    end
    exp_q.push_back(expect_word(a, b));
    tag_q.push_back(tag);
    @(negedge clk);
    lead_valid = 1'b0; lag_valid = 1'b0; cfg_wr = 1'b0;
    if (wr) begin
      if (sel) gm_lag = wval; else gm_lead = wval;
    end
  endtask

  task automatic write_gain(input bit sel, input int val);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val[15:0];
    @(negedge clk);
    cfg_wr = 1'b0;
    if (sel) gm_lag = val; else gm_lead = val;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [OUT_W-1:0] held;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid === 1'b0, "R1 out_valid after reset", OUT_W'(out_valid), '0);
    check(align_err === 1'b0, "R1 align_err after reset", OUT_W'(align_err), '0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(in_ready === 1'b1, "R2 ready when empty", OUT_W'(in_ready), OUT_W'(1));

    // R1/R3: unity gains, identity pass-through and lane order.
    send(pk(1, 3, 5, 7), pk(2, 4, 6, 8), "R1/R3 unity ramp order", 0, 0, 0);
    send(pk(-2048, 2047, -1, 0), pk(2047, -2048, 1, -5), "R3 extremes unity", 0, 0, 0);
    drain();

    // R4/R10: distinct gains per channel, exact-half rounding.
    write_gain(0, 16384);
    write_gain(1, 24576);
    send(pk(3, -3, 1, -1), pk(3, -3, 2, -2), "R4/R10 half rounding", 0, 0, 0);
    send(pk(1000, -1000, 777, -777), pk(1000, -1000, 777, -777), "R4 scaled values", 0, 0, 0);
    // R6: zero in, zero out.
    send(pk(0, 0, 0, 0), pk(0, 0, 0, 0), "R6 zero no offset", 0, 0, 0);
    drain();

    // R5: saturation at both ends.
    write_gain(0, 65535);
    write_gain(1, 65535);
    send(pk(2047, -2048, 1100, -1100), pk(1500, -1500, 1023, -1025), "R5 clamp", 0, 0, 0);
    drain();

    // R7: write in the same cycle as acceptance uses old gain.
    write_gain(0, 32768);
    write_gain(1, 32768);
    send(pk(100, 201, -301, 5), pk(400, -17, 9, 33), "R7 same-cycle old gain", 1, 0, 8192);
    send(pk(100, 201, -301, 5), pk(400, -17, 9, 33), "R7 next word new gain", 1, 1, 49152);
    send(pk(100, 201, -301, 5), pk(400, -17, 9, 33), "R7/R10 both updated", 0, 0, 0);
    drain();

    // R9: stall the output.
    bp_mode = 1;
    send(pk(11, 12, 13, 14), pk(21, 22, 23, 24), "R9 stalled word 1", 0, 0, 0);
    send(pk(31, 32, 33, 34), pk(41, 42, 43, 44), "R9 stalled word 2", 0, 0, 0);
    @(negedge clk); #1;
    check(in_ready === 1'b0, "R9 ready low when full", OUT_W'(in_ready), '0);
    held = out_data;
    check(out_valid === 1'b1, "R9 valid while stalled", OUT_W'(out_valid), OUT_W'(1));
    repeat (4) @(negedge clk);
    #1;
    check(out_data === held && out_valid === 1'b1, "R9 data held", out_data, held);
    bp_mode = 0;
    drain();

    // R8: skewed valid beat.
    @(negedge clk);
    lead_valid = 1'b1; lead_data = pk(99, 99, 99, 99);
    @(negedge clk);
    lead_valid = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check(align_err === 1'b1, "R8 flag set", OUT_W'(align_err), OUT_W'(1));
    check(out_valid === 1'b0, "R8 no word from lone beat", OUT_W'(out_valid), '0);
    send(pk(7, 6, 5, 4), pk(3, 2, 1, 0), "R8 stream continues", 0, 0, 0);
    drain();
    #1;
    check(align_err === 1'b1, "R8 flag sticky", OUT_W'(align_err), OUT_W'(1));

    // R2/R4/R5: random words under random back-pressure with gain changes.
    bp_mode = 2;
    for (int i = 0; i < 40; i++) begin
      if (i % 9 == 4) write_gain(i[0], int'($urandom % 65536));
      send(IN_W'({$urandom, $urandom}), IN_W'({$urandom, $urandom}),
           "R2/R4/R5 random", (i % 7 == 3), i[1], int'($urandom % 65536));
    end
    bp_mode = 0;
    drain();
    check(exp_q.size() == 0, "R2 all words delivered", OUT_W'(exp_q.size()), '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule